// File: doc/BRIEF.md
# Soft-Decision Threshold Decoder

This block decodes a systematic rate-1/2 self-orthogonal convolutional code with generator 1 + D + D^4 + D^6 (memory 6, four orthogonal checks on each information bit). Each valid cycle it takes one received information symbol and one received parity symbol. Both are soft words: a hard bit plus a reliability magnitude. For each valid cycle it returns one hard decoded information bit.

The decision for the oldest information bit is a weighted vote. Each orthogonal check combines its parity cell with the still-undecoded information symbols it contains. The combining rule XORs the hard bits and takes the smallest reliability. Each check then votes with that reliability for the value it implies. The received symbol of the bit itself also votes with its own reliability, and the heavier side wins. The decoded bit is written back into the parity cells it affects, at full reliability. Later checks therefore see past decisions in place of the raw received data.

The block is used as a stream filter behind a soft demodulator. The decoder starts from an all-zero state, so the encoder must start from an all-zero state too. Output pulse k after reset carries information bit k-7.

Top module: `softThreshDecoder`

## Requirements
- R1: A symbol is Q bits wide. Bit Q-1 is the hard value. Bits Q-2..0 are an unsigned reliability, where a larger value means more confidence. A clean stream whose symbols carry any mix of non-zero reliabilities is decoded exactly.
- R2: The reset is synchronous and active high. In the cycle after a reset, outValid and outBit are 0. Afterwards the decoder behaves as if every stored symbol were a hard 0 with reliability 0.
- R3: outValid is 1 in the cycle after each cycle with inValid high, and 0 in every other cycle. A cycle with inValid low changes neither the stored symbols nor outBit.
- R4: Output pulse number k after reset (counting from 0) carries the decoded bit for information index k-7. For a stream encoded from the zero state, pulses 0 to 6 carry 0.
- R5: An error-free stream at full reliability (all reliability bits 1) is decoded exactly.
- R6: Every decoded bit is correct under two conditions. Any 13 consecutive indices hold at most two errored symbols (information or parity, any reliability). All other symbols are at full reliability.
- R7: Take a bit t and flip the parity symbols at indices t+1, t+4 and t+6, each with reliability 1, with all other symbols correct and at full reliability. Bit t is still decoded correctly, although three of its four checks oppose it.
- R8: When the two vote weights are equal, the received hard bit is kept. In particular, while every symbol since reset has reliability 0, output pulse k equals the received hard information bit of index k-7.
- R9: Each decoded bit is fed back into the parity cells of its later checks at full reliability. A full-reliability information error every 16 indices is corrected, and the bits after it are decoded correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A symbol pair is present this cycle |
| infoSym | input | Q | Received information symbol, hard bit in the MSB |
| parSym | input | Q | Received parity symbol, hard bit in the MSB |
| outValid | output | 1 | A decoded bit is present this cycle |
| outBit | output | 1 | Decoded information bit |

## Verification
The hardest situation to reach from the ports is a decision in which the weighted vote must overrule a hard majority. That happens when three of a bit's four checks are wrong, each with low confidence. The stimulus reaches it by corrupting exactly the parity symbols at offsets 1, 4 and 6 after the target bit, at reliability 1, inside an otherwise clean full-confidence stretch. It keeps each such group far enough from the next that no other decision sees more than two of those parity errors. A second hard case is the tie rule. Zero reliability across the whole stream removes every vote, so the output must be the raw received information delayed by seven pulses, errors included.

// File: rtl/softDecPkg.sv
package softDecPkg;
  // code memory and orthogonal check taps of the generator 1 + D + D^4 + D^6
  localparam int CODE_MEM   = 6;
  localparam int NUM_CHECKS = 4;
  localparam int CHECK_TAPS [NUM_CHECKS] = '{0, 1, 4, 6};

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic shift;
  } decStrobe_t;
endpackage

// File: rtl/softDecCtrl.sv
module softDecCtrl
  import softDecPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output decStrobe_t strobe,
  output logic       outValid
);
  always_comb begin
    strobe.clear = rst;
    strobe.shift = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end
endmodule

// File: rtl/softDecVoter.sv
module softDecVoter
  import softDecPkg::*;
#(
  parameter int Q = 3
) (
  input  logic [CODE_MEM:0][Q-1:0] infoLine,
  input  logic [CODE_MEM:0][Q-1:0] parLine,
  output logic                     decided
);
  localparam int RW  = Q - 1;
  localparam int SW  = RW + $clog2(NUM_CHECKS + 2);
  localparam int MEM = CODE_MEM;

  // hard bits combine by XOR, reliabilities by minimum
  function automatic logic [Q-1:0] addMin(input logic [Q-1:0] a, input logic [Q-1:0] b);
    logic [RW-1:0] r;
    r = (a[RW-1:0] < b[RW-1:0]) ? a[RW-1:0] : b[RW-1:0];
    return {a[Q-1] ^ b[Q-1], r};
  endfunction

  logic [NUM_CHECKS-1:0][Q-1:0] checkVal;
  logic [SW-1:0] flipSum;
  logic [SW-1:0] keepSum;
  logic          oldHard;

  always_comb begin
    oldHard = infoLine[MEM][Q-1];
    flipSum = '0;
    keepSum = SW'(infoLine[MEM][RW-1:0]);
    for (int k = 0; k < NUM_CHECKS; k++) begin
      checkVal[k] = parLine[MEM - CHECK_TAPS[k]];
      for (int l = 0; l < NUM_CHECKS; l++) begin
        int age;
        age = (CHECK_TAPS[l] < CHECK_TAPS[k]) ? (MEM - CHECK_TAPS[k] + CHECK_TAPS[l]) : MEM;
        if (CHECK_TAPS[l] < CHECK_TAPS[k])
          checkVal[k] = addMin(checkVal[k], infoLine[age]);
      end
      if (checkVal[k][Q-1] != oldHard) flipSum = flipSum + SW'(checkVal[k][RW-1:0]);
      else                             keepSum = keepSum + SW'(checkVal[k][RW-1:0]);
    end
    decided = oldHard ^ (flipSum > keepSum);
  end
endmodule

// File: rtl/softDecPath.sv
module softDecPath
  import softDecPkg::*;
#(
  parameter int Q = 3
) (
  input  logic       clk,
  input  decStrobe_t strobe,
  input  logic [Q-1:0] infoSym,
  input  logic [Q-1:0] parSym,
  output logic       outBit
);
  localparam int RW  = Q - 1;
  localparam int MEM = CODE_MEM;
  localparam logic [RW-1:0] FULL_REL = {RW{1'b1}};

  function automatic logic [Q-1:0] addMin(input logic [Q-1:0] a, input logic [Q-1:0] b);
    logic [RW-1:0] r;
    r = (a[RW-1:0] < b[RW-1:0]) ? a[RW-1:0] : b[RW-1:0];
    return {a[Q-1] ^ b[Q-1], r};
  endfunction

  logic [MEM:0][Q-1:0] infoLine;
  logic [MEM:0][Q-1:0] parLine;
  logic [MEM:0][Q-1:0] parNext;
  logic                decided;

  softDecVoter #(.Q(Q)) uVoter (
    .infoLine(infoLine),
    .parLine (parLine),
    .decided (decided)
  );

  // shift the parity cells and fold the fresh decision into its later checks
  always_comb begin
    parNext[0] = parSym;
    for (int a = 1; a <= MEM; a++) parNext[a] = parLine[a-1];
    for (int k = 0; k < NUM_CHECKS; k++) begin
      int pos;
      pos = (CHECK_TAPS[k] > 0) ? (MEM - CHECK_TAPS[k]) : 0;
      if (CHECK_TAPS[k] > 0)
        parNext[pos + 1] = addMin(parLine[pos], {decided, FULL_REL});
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      infoLine <= '0;
      parLine  <= '0;
      outBit   <= 1'b0;
    end else if (strobe.shift) begin
      infoLine <= {infoLine[MEM-1:0], infoSym};
      parLine  <= parNext;
      outBit   <= decided;
    end
  end
endmodule

// File: rtl/softThreshDecoder.sv
module softThreshDecoder
  import softDecPkg::*;
#(
  parameter int Q = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic [Q-1:0] infoSym,
  input  logic [Q-1:0] parSym,
  output logic         outValid,
  output logic         outBit
);
  decStrobe_t strobe;

  softDecCtrl uCtrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  softDecPath #(.Q(Q)) uPath (
    .clk    (clk),
    .strobe (strobe),
    .infoSym(infoSym),
    .parSym (parSym),
    .outBit (outBit)
  );
endmodule

// File: rtl/softDecChecker.sv
module softDecChecker
  import softDecPkg::*;
#(
  parameter int Q = 3
) (
  input logic         clk,
  input logic         rst,
  input logic         inValid,
  input logic [Q-1:0] infoSym,
  input logic [Q-1:0] parSym,
  input logic         outValid,
  input logic         outBit
);
  logic [CODE_MEM:0] hardHist;
  logic              zeroSoFar;

  always_ff @(posedge clk) begin
    if (rst) begin
      hardHist  <= '0;
      zeroSoFar <= 1'b1;
    end else if (inValid) begin
      hardHist  <= {hardHist[CODE_MEM-1:0], infoSym[Q-1]};
      zeroSoFar <= zeroSoFar & (infoSym[Q-2:0] == '0) & (parSym[Q-2:0] == '0);
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!outValid && !outBit));  // R2
  AST_VALID_PACE: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);  // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);  // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(outBit));  // R3
  AST_ZERO_REL_KEEP: assert property (@(posedge clk) disable iff (rst)
    (inValid && zeroSoFar) |=> (outBit == $past(hardHist[CODE_MEM])));  // R8
endmodule

bind softThreshDecoder softDecChecker #(.Q(Q)) uChk (
  .clk     (clk),
  .rst     (rst),
  .inValid (inValid),
  .infoSym (infoSym),
  .parSym  (parSym),
  .outValid(outValid),
  .outBit  (outBit)
);

// File: tb/tb_softThreshDecoder.sv
module tb_softThreshDecoder;
  localparam int CLK_PERIOD = 10;
  localparam int Q    = 3;
  localparam int RW   = Q - 1;
  localparam int FULL = (1 << RW) - 1;
  localparam int NMAX = 256;
  localparam int LAT  = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [Q-1:0] infoSym = '0;
  logic [Q-1:0] parSym = '0;
  logic outValid;
  logic outBit;

  softThreshDecoder #(.Q(Q)) dut (
    .clk(clk), .rst(rst), .inValid(inValid), .infoSym(infoSym),
    .parSym(parSym), .outValid(outValid), .outBit(outBit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit dataBits [NMAX];
  bit eInfo [NMAX];
  bit ePar [NMAX];
  int eRel [NMAX];
  bit expBits [NMAX];
  int goodMin, goodMax;
  int outCnt;
  bit prevValid;
  bit lastOut;
  string curTag;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit encPar(input int n);
    bit p;
    int taps [4];
    p = 1'b0;
    taps = '{0, 1, 4, 6};
    foreach (taps[t]) if (n - taps[t] >= 0) p ^= dataBits[n - taps[t]];
    return p;
  endfunction

  function automatic logic [Q-1:0] mkSym(input bit hard, input int rel);
    return {hard, RW'(rel)};
  endfunction

  task automatic sampleOut();
    check(outValid == prevValid, "R3", int'(outValid), int'(prevValid));
    if (outValid) begin
      if (outCnt < NMAX)
        check(outBit == expBits[outCnt], (outCnt < LAT) ? "R4" : curTag,
              int'(outBit), int'(expBits[outCnt]));
      lastOut = outBit;
      outCnt++;
    end else begin
      check(outBit == lastOut, "R3", int'(outBit), int'(lastOut));
    end
  endtask

  task automatic tick(input bit v, input logic [Q-1:0] i, input logic [Q-1:0] p);
    @(negedge clk);
    sampleOut();
    inValid = v;
    infoSym = i;
    parSym = p;
    prevValid = v;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R2", int'(outValid), 0);
    check(outBit == 1'b0, "R2", int'(outBit), 0);
    @(negedge clk);
    rst = 1'b0;
    prevValid = 1'b0;
    lastOut = 1'b0;
    outCnt = 0;
  endtask

  task automatic newPattern();
    for (int k = 0; k < NMAX; k++) begin
      dataBits[k] = 1'($urandom_range(0, 1));
      eInfo[k] = 1'b0;
      ePar[k] = 1'b0;
      eRel[k] = 0;
    end
    goodMin = FULL;
    goodMax = FULL;
  endtask

  task automatic streamRun(input int n, input int gapPct, input bit expRx, input string tag);
    curTag = tag;
    for (int k = 0; k < n; k++)
      expBits[k] = (k < LAT) ? 1'b0 : (dataBits[k-LAT] ^ (expRx & eInfo[k-LAT]));
    doReset();
    for (int idx = 0; idx < n; idx++) begin
      int gi, gp;
      while (int'($urandom_range(0, 99)) < gapPct) tick(1'b0, '0, '0);
      gi = int'($urandom_range(goodMin, goodMax));
      gp = int'($urandom_range(goodMin, goodMax));
      tick(1'b1,
           mkSym(dataBits[idx] ^ eInfo[idx], eInfo[idx] ? eRel[idx] : gi),
           mkSym(encPar(idx) ^ ePar[idx], ePar[idx] ? eRel[idx] : gp));
    end
    tick(1'b0, '0, '0);
    tick(1'b0, '0, '0);
    check(outCnt == n, tag, outCnt, n);
  endtask

  task automatic testResetState();
    doReset();
    repeat (20) begin
      @(negedge clk);
      inValid = 1'b1;
      infoSym = Q'($urandom);
      parSym = Q'($urandom);
    end
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R2", int'(outValid), 0);
    check(outBit == 1'b0, "R2", int'(outBit), 0);
    rst = 1'b0;
    newPattern();
    streamRun(60, 0, 1'b0, "R2");
  endtask

  task automatic testClean();
    newPattern();
    streamRun(200, 0, 1'b0, "R5");
  endtask

  task automatic testSoftLevels();
    newPattern();
    goodMin = 1;
    streamRun(200, 0, 1'b0, "R1");
  endtask

  task automatic testGaps();
    newPattern();
    streamRun(150, 30, 1'b0, "R3");
  endtask

  task automatic placeDoubles(input bit lowConf);
    for (int g = 20; g + 12 < 220; g += 20) begin
      int s1, s2;
      s1 = int'($urandom_range(0, 3));
      s2 = (s1 + 1 + int'($urandom_range(0, 2))) % 4;
      foreach (eRel[x]) if (x == g || x == g + 1)
        eRel[x] = lowConf ? int'($urandom_range(0, FULL)) : FULL;
      if (s1 % 2 == 0) eInfo[g + s1 / 2] = 1'b1; else ePar[g + s1 / 2] = 1'b1;
      if (s2 % 2 == 0) eInfo[g + s2 / 2] = 1'b1; else ePar[g + s2 / 2] = 1'b1;
    end
  endtask

  task automatic testDouble();
    newPattern();
    placeDoubles(1'b0);
    streamRun(220, 0, 1'b0, "R6");
  endtask

  task automatic testDoubleLowConf();
    newPattern();
    placeDoubles(1'b1);
    streamRun(220, 10, 1'b0, "R6");
  endtask

  task automatic testFeedback();
    newPattern();
    for (int g = 20; g < 200; g += 16) begin
      eInfo[g] = 1'b1;
      eRel[g] = FULL;
    end
    streamRun(210, 0, 1'b0, "R9");
  endtask

  task automatic testWeighted();
    newPattern();
    for (int t = 30; t < 200; t += 40) begin
      ePar[t+1] = 1'b1; eRel[t+1] = 1;
      ePar[t+4] = 1'b1; eRel[t+4] = 1;
      ePar[t+6] = 1'b1; eRel[t+6] = 1;
    end
    streamRun(215, 0, 1'b0, "R7");
  endtask

  task automatic testZeroRel();
    newPattern();
    goodMin = 0;
    goodMax = 0;
    for (int k = 0; k < 200; k++) begin
      eInfo[k] = ($urandom_range(0, 7) == 0);
      ePar[k] = ($urandom_range(0, 7) == 0);
    end
    streamRun(200, 0, 1'b1, "R8");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "R3 watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    outCnt = 0;
    prevValid = 1'b0;
    lastOut = 1'b0;
    curTag = "R2";
    testResetState();
    testClean();
    testSoftLevels();
    testGaps();
    testDouble();
    testDoubleLowConf();
    testFeedback();
    testWeighted();
    testZeroRel();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule